// File: doc/BRIEF.md
# Debug Wire Acknowledge and Sync Controller

This block sits on the target side of a single-wire, open-drain debug port. Its job is the optional acknowledge handshake. A flag, cleared at reset, is set by an "acknowledge on" command and cleared by an "acknowledge off" command. While the flag is set, the block answers each finished read or write with an acknowledge pulse on the shared wire. The pulse pulls the wire low for a fixed number of target clocks. It then drives the wire high for one speedup cycle and releases it. While the flag is clear, the host has to wait out worst-case delays instead.

The block also watches the sampled wire level for a long low pulse from the host, which is a synchronization request. It reports that request with a one-cycle strobe. There is no arbitration between its own pulse and a host sync pulse that overlap. Low samples taken while the block itself drives the wire are not counted towards a sync.

All inputs are decoded single-cycle strobes or levels from the neighbouring serial and bus logic. None of them carries a data stream, so there is no valid/ready interface and no back-pressure. A request that cannot be served at once waits in a single pending slot.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: After reset, drive_low, drive_high and sync_seen are 0 and the handshake is disabled, so a later read completion produces no pulse.
- R2: An ack_on_cmd strobe enables the handshake and is itself acknowledged, including when the handshake is already enabled; from an idle wire the pulse starts in the cycle after the strobe is sampled.
- R3: An ack_off_cmd strobe disables the handshake and produces no pulse. It also discards a pending request. While disabled, no read or write completion drives the wire. If both command strobes arrive in the same cycle, the disable takes precedence.
- R4: With the handshake enabled, rd_bus_done starts a pulse in the cycle after it is sampled.
- R5: With the handshake enabled, a write is acknowledged only once both wr_data_rcvd and wr_bus_done have been seen, in either order or in the same cycle. The pulse starts in the cycle after the later of the two is sampled.
- R6: A pulse holds drive_low for 16 cycles, then drive_high for exactly 1 cycle, then releases both. drive_low and drive_high are never 1 together.
- R7: A request that arrives while a pulse is running is held. A new pulse starts directly after the speedup cycle. Several such requests collapse into one extra pulse.
- R8: sync_seen is a one-cycle strobe. It appears in the cycle after the first high sample of wire_in that follows at least 128 consecutive low samples. A run of 127 low samples gives no strobe.
- R9: Low samples of wire_in taken while drive_low or drive_high is 1 are not counted, and they restart the low run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_on_cmd | input | 1 | Decoded enable-handshake command strobe |
| ack_off_cmd | input | 1 | Decoded disable-handshake command strobe |
| rd_bus_done | input | 1 | Read bus cycle finished, data ready to shift out |
| wr_data_rcvd | input | 1 | Serial write data fully received |
| wr_bus_done | input | 1 | Write bus cycle finished |
| wire_in | input | 1 | Synchronized level of the debug wire |
| drive_low | output | 1 | Enable for the pull-low driver on the wire |
| drive_high | output | 1 | Enable for the speedup drive-high driver |
| sync_seen | output | 1 | One-cycle strobe: host sync request detected |

## Verification
Every pulse starts one cycle after its triggering strobe is sampled. It lasts 16 cycles low and 1 cycle high, and the wire is idle on the 18th cycle. The sync strobe is due one cycle after the first high sample that ends the low run. Inputs change on the falling edge, and outputs are compared on each following falling edge against a cycle index counted from the triggering rising edge. A pulse window therefore checks all 18 cycles one by one, and a sync test checks both the cycle the strobe is due and the cycle after it.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/ack_request.sv
// Enable flag and completion tracking; emits a one-cycle pulse request.
module ack_request (
  input  logic clk,
  input  logic rst_n,
  input  logic on_cmd,
  input  logic off_cmd,
  input  logic rd_done,
  input  logic wr_rcvd,
  input  logic wr_bus,
  output logic req,
  output logic cancel
);
  logic en_q, rx_seen_q, bus_seen_q, wr_complete;

  assign wr_complete = (wr_rcvd | rx_seen_q) & (wr_bus | bus_seen_q);
  // disable wins over everything in the same cycle
  assign req    = ~off_cmd & (on_cmd | (en_q & (rd_done | wr_complete)));
  assign cancel = off_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      rx_seen_q  <= 1'b0;
      bus_seen_q <= 1'b0;
    end else begin
      if (off_cmd)     en_q <= 1'b0;
      else if (on_cmd) en_q <= 1'b1;

      if (off_cmd || wr_complete) begin
        rx_seen_q  <= 1'b0;
        bus_seen_q <= 1'b0;
      end else begin
        rx_seen_q  <= rx_seen_q | wr_rcvd;
        bus_seen_q <= bus_seen_q | wr_bus;
      end
    end
  end
endmodule

// File: rtl/ack_pulse_gen.sv
// Low phase, speedup phase, single pending slot.
module ack_pulse_gen
  import dbg_ack_pkg::*;
#(
  parameter int LOW_CYCLES  = 16,
  parameter int HIGH_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic cancel,
  output logic drv_low,
  output logic drv_high
);
  localparam int MAXC = (LOW_CYCLES > HIGH_CYCLES) ? LOW_CYCLES : HIGH_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYCLES - 1);

  ack_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          pend_q <= 1'b0;
          if (req) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end
        end
        PH_LOW: begin
          pend_q <= cancel ? 1'b0 : (pend_q | req);
          if (cnt_q == LOW_LAST) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == HIGH_LAST) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            if (req || (pend_q && !cancel)) phase_q <= PH_LOW;
            else                            phase_q <= PH_IDLE;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            pend_q <= cancel ? 1'b0 : (pend_q | req);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign drv_low  = (phase_q == PH_LOW);
  assign drv_high = (phase_q == PH_HIGH);
endmodule

// File: rtl/sync_detect.sv
// Counts consecutive undriven low samples; strobes on the rising return.
module sync_detect #(
  parameter int SYNC_MIN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wire_in,
  input  logic driving,
  output logic sync_seen
);
  localparam int SW = $clog2(SYNC_MIN + 1);
  localparam logic [SW-1:0] SYNC_SAT = SW'(SYNC_MIN);

  logic [SW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      sync_seen <= 1'b0;
    end else begin
      sync_seen <= 1'b0;
      if (driving) begin
        run_q <= '0;
      end else if (!wire_in) begin
        if (run_q != SYNC_SAT) run_q <= run_q + 1'b1;
      end else begin
        sync_seen <= (run_q == SYNC_SAT);
        run_q     <= '0;
      end
    end
  end
endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl #(
  parameter int LOW_CYCLES  = 16,
  parameter int HIGH_CYCLES = 1,
  parameter int SYNC_MIN    = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_on_cmd,
  input  logic ack_off_cmd,
  input  logic rd_bus_done,
  input  logic wr_data_rcvd,
  input  logic wr_bus_done,
  input  logic wire_in,
  output logic drive_low,
  output logic drive_high,
  output logic sync_seen
);
  logic req, cancel;

  ack_request u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .on_cmd  (ack_on_cmd),
    .off_cmd (ack_off_cmd),
    .rd_done (rd_bus_done),
    .wr_rcvd (wr_data_rcvd),
    .wr_bus  (wr_bus_done),
    .req     (req),
    .cancel  (cancel)
  );

  ack_pulse_gen #(
    .LOW_CYCLES  (LOW_CYCLES),
    .HIGH_CYCLES (HIGH_CYCLES)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .cancel   (cancel),
    .drv_low  (drive_low),
    .drv_high (drive_high)
  );

  sync_detect #(
    .SYNC_MIN (SYNC_MIN)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .wire_in   (wire_in),
    .driving   (drive_low | drive_high),
    .sync_seen (sync_seen)
  );
endmodule

// File: rtl/dbg_ack_chk.sv
module dbg_ack_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_on_cmd,
  input logic ack_off_cmd,
  input logic wire_in,
  input logic drive_low,
  input logic drive_high,
  input logic sync_seen
);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low && drive_high));
  // R6
  speedup_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> drive_high);
  // R6
  speedup_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_high |=> !drive_high);
  // R2
  on_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_on_cmd && !ack_off_cmd && !drive_low && !drive_high) |=> drive_low);
  // R3
  off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_off_cmd |=> !$rose(drive_low));
  // R8
  sync_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_seen |=> !sync_seen);
  // R8
  sync_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_seen |-> $past(wire_in));
endmodule

bind dbg_ack_ctrl dbg_ack_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_on_cmd  (ack_on_cmd),
  .ack_off_cmd (ack_off_cmd),
  .wire_in     (wire_in),
  .drive_low   (drive_low),
  .drive_high  (drive_high),
  .sync_seen   (sync_seen)
);

// File: tb/dbg_ack_ctrl_test.sv
`timescale 1ns/1ps
module dbg_ack_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_on_cmd = 1'b0, ack_off_cmd = 1'b0, rd_bus_done = 1'b0;
  logic wr_data_rcvd = 1'b0, wr_bus_done = 1'b0, wire_in = 1'b1;
  logic drive_low, drive_high, sync_seen;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbg_ack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ack_on_cmd(ack_on_cmd), .ack_off_cmd(ack_off_cmd),
    .rd_bus_done(rd_bus_done), .wr_data_rcvd(wr_data_rcvd), .wr_bus_done(wr_bus_done),
    .wire_in(wire_in), .drive_low(drive_low), .drive_high(drive_high),
    .sync_seen(sync_seen)
  );

  // command codes: 0 read, 1 write both at once, 2 enable, 3 disable, 4 write split
  // entry = {cmd[2:0], pulse expected}
  localparam logic [3:0] VEC [0:9] = '{
    {3'd0, 1'b0}, {3'd1, 1'b0}, {3'd2, 1'b1}, {3'd0, 1'b1}, {3'd1, 1'b1},
    {3'd4, 1'b1}, {3'd2, 1'b1}, {3'd3, 1'b0}, {3'd0, 1'b0}, {3'd4, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(drive_low == 1'b0 && drive_high == 1'b0, tag,
          {drive_low, drive_high}, 0);
  endtask

  // Entered at a falling edge with strobes set; samples 18 cycles after the edge.
  task automatic watch_pulse(input bit exp, input string tag);
    for (int i = 1; i <= 18; i++) begin
      if (i > 1) tick();
      check(drive_low == (exp && i <= 16) && drive_high == (exp && i == 17),
            tag, {drive_low, drive_high}, {exp && i <= 16, exp && i == 17});
    end
  endtask

  task automatic do_cmd(input logic [2:0] cmd, input bit exp, input string tag);
    if (cmd == 3'd4) begin
      wr_data_rcvd = 1'b1;
      tick();
      wr_data_rcvd = 1'b0;
      check_idle({tag, " R5 split gap"});
      tick();
      check_idle({tag, " R5 split gap"});
      wr_bus_done = 1'b1;
    end else begin
      case (cmd)
        3'd0: rd_bus_done = 1'b1;
        3'd1: begin wr_data_rcvd = 1'b1; wr_bus_done = 1'b1; end
        3'd2: ack_on_cmd = 1'b1;
        default: ack_off_cmd = 1'b1;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    ack_on_cmd = 0; ack_off_cmd = 0; rd_bus_done = 0; wr_data_rcvd = 0; wr_bus_done = 0;
    watch_pulse(exp, tag);
  endtask

  task automatic sync_run(input int lows, input bit exp, input string tag);
    wire_in = 1'b0;
    for (int i = 0; i < lows; i++) begin
      tick();
      check(sync_seen == 1'b0, tag, sync_seen, 0);
    end
    wire_in = 1'b1;
    tick();
    check(sync_seen == exp, tag, sync_seen, exp);
    tick();
    check(sync_seen == 1'b0, {tag, " strobe width"}, sync_seen, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drive_low == 0 && drive_high == 0 && sync_seen == 0, "R1 reset outputs",
          {drive_low, drive_high, sync_seen}, 0);
    rst_n = 1'b1;
    tick();

    // table walk: R2 enable acked, R3 disabled/no ack, R4 read, R5 write, R6 shape
    for (int v = 0; v < 10; v++) begin
      do_cmd(VEC[v][3:1], VEC[v][0], $sformatf("vec%0d R2 R3 R4 R5 R6", v));
    end

    // R7 pending: two requests during the first pulse collapse into one more pulse
    do_cmd(3'd2, 1'b1, "R2 re-enable");
    rd_bus_done = 1'b1;
    @(posedge clk);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      rd_bus_done = (i == 5 || i == 8);
      check(drive_low == ((i <= 16) || (i >= 18 && i <= 33)) &&
            drive_high == (i == 17 || i == 34), "R7 pending pulse",
            {drive_low, drive_high},
            {((i <= 16) || (i >= 18 && i <= 33)), (i == 17 || i == 34)});
      @(posedge clk);
    end
    @(negedge clk);

    // R3: disable during a pulse drops the pending request
    rd_bus_done = 1'b1;
    @(posedge clk);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      rd_bus_done = (i == 3);
      ack_off_cmd = (i == 6);
      check(drive_low == (i <= 16) && drive_high == (i == 17), "R3 off drops pending",
            {drive_low, drive_high}, {i <= 16, i == 17});
      @(posedge clk);
    end
    @(negedge clk);
    do_cmd(3'd0, 1'b0, "R3 still disabled");

    // R3: simultaneous enable and disable, disable wins
    ack_on_cmd = 1'b1;
    ack_off_cmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack_on_cmd = 0; ack_off_cmd = 0;
    watch_pulse(1'b0, "R3 both strobes");
    do_cmd(3'd0, 1'b0, "R3 both strobes leave disabled");

    // R8 sync thresholds
    sync_run(128, 1'b1, "R8 sync 128");
    sync_run(127, 1'b0, "R8 sync 127");
    sync_run(200, 1'b1, "R8 sync 200");

    // R9: own pulse lows do not count
    do_cmd(3'd2, 1'b1, "R2 enable for R9");
    rd_bus_done = 1'b1;
    tick();
    rd_bus_done = 1'b0;
    wire_in = 1'b0;
    for (int i = 0; i < 17; i++) tick();
    for (int i = 0; i < 127; i++) tick();
    wire_in = 1'b1;
    tick();
    check(sync_seen == 1'b0, "R9 driven lows ignored", sync_seen, 0);
    tick();

    // R1: reset clears the enable flag
    rst_n = 1'b0;
    tick();
    check(drive_low == 0 && drive_high == 0 && sync_seen == 0, "R1 mid reset",
          {drive_low, drive_high, sync_seen}, 0);
    rst_n = 1'b1;
    tick();
    do_cmd(3'd0, 1'b0, "R1 disabled after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule